// File: doc/BRIEF.md
# Ten-to-one serializer with internal wrap routing

This block turns a stream of 10-bit symbols, already line-coded upstream, into a single serial bit stream at ten bits per symbol. It runs entirely on the bit clock. The symbol period is a repeating window of ten bit cycles. The last cycle of each window is the word boundary. At that boundary the next symbol moves into the shift register, and the symbol is then sent one bit per cycle, bit 0 first and bit 9 last.

Symbols arrive on a valid/ready interface and land in a one-word holding register. Ready is high whenever that register is empty, or whenever the current cycle is a word boundary, because the held word leaves at that edge. A source that keeps valid high therefore gets back-to-back symbols with no gap between them. If no symbol is held when a boundary arrives, ten idle ones are sent instead. The source must hold valid and data steady until the handshake completes.

A loopback request pin chooses where the stream goes. When it is low, the stream drives the external serial pin and the wrap pin idles high. When it is high, the external pin is held at logic 1 and the stream appears on the wrap pin, which feeds a receiver input. The request is sampled only at word boundaries, so neither pin ever carries a partial symbol.

Top module: `ser_loop_tx`

## Requirements
- R1: While rst_n is low, and until the first boundary that follows, ser_out and wrap_out are 1 and in_ready is 1.
- R2: in_ready is high exactly when the holding register is empty or the current cycle is a word boundary. A symbol is taken on a clock edge where in_valid and in_ready are both high. A held symbol is neither lost nor changed before it is loaded.
- R3: A symbol loaded at a boundary appears on the active output over the next ten cycles as bit 0, bit 1, and so on up to bit 9, one bit per cycle.
- R4: When a symbol is held at a boundary, its bit 0 follows the previous symbol's bit 9 in the very next cycle, with no gap.
- R5: When no symbol is held at a boundary, the next ten output cycles carry logic 1.
- R6: With loopback off, ser_out carries the stream and wrap_out is 1.
- R7: With loopback on, ser_out is 1 and wrap_out carries the stream.
- R8: loop_en is sampled only at word boundaries. A change between boundaries leaves the routing of the current symbol unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol offered |
| in_ready | output | 1 | Symbol can be taken this cycle |
| in_data | input | 10 | Encoded symbol, bit 0 sent first |
| loop_en | input | 1 | Request to wrap the stream internally |
| ser_out | output | 1 | External serial output |
| wrap_out | output | 1 | Internal wrap output toward the receiver |

## Verification
The bench uses the default 10-bit symbol width, so the window is ten cycles and the counter wraps from 9 to 0. This width covers the full bit order, the idle fill, back-to-back symbols when valid is held high, and gaps when valid is sparse. Loopback is tested three ways: held low, held high, and toggled at random points, including mid-word. The toggled case exposes any routing change that happens away from a boundary.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int unsigned SYM_W = 10;
  typedef enum logic {ROUTE_EXT = 1'b0, ROUTE_WRAP = 1'b1} route_e;
endpackage

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
  parameter int unsigned SYM_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic boundary
);
  localparam int unsigned CW = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= LAST;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign boundary = (cnt == LAST);

  // R4: the window restarts immediately after its last cycle
  p_wrap_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0));
endmodule

// File: rtl/ser_word_latch.sv
module ser_word_latch #(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             boundary,
  output logic             hold_valid,
  output logic [SYM_W-1:0] hold_data
);
  logic take;

  assign in_ready = !hold_valid || boundary;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (take) begin
      hold_valid <= 1'b1;
      hold_data  <= in_data;
    end else if (boundary) begin
      hold_valid <= 1'b0;
    end
  end

  // R2: a held symbol stays intact until a boundary consumes it
  p_hold_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !boundary) |=> (hold_valid && $stable(hold_data)));
  // R2: a boundary with no new offer empties the holding register
  p_hold_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !in_valid) |=> !hold_valid);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_tx_pkg::*;
#(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             hold_valid,
  input  logic [SYM_W-1:0] hold_data,
  input  logic             loop_req,
  output logic             line_bit,
  output route_e           route
);
  logic [SYM_W-1:0] shreg;
  logic [SYM_W-1:0] shifted;

  generate
    for (genvar i = 0; i < SYM_W; i++) begin : g_fill
      if (i == SYM_W - 1) begin : g_top
        assign shifted[i] = 1'b1;
      end else begin : g_mid
        assign shifted[i] = shreg[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      route <= ROUTE_EXT;
    end else if (boundary) begin
      shreg <= hold_valid ? hold_data : '1;
      route <= loop_req ? ROUTE_WRAP : ROUTE_EXT;
    end else begin
      shreg <= shifted;
    end
  end

  assign line_bit = shreg[0];

  // R8: routing moves only at a word boundary
  p_route_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> $stable(route));
  // R5: an empty boundary produces an idle bit next
  p_idle_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !hold_valid) |=> line_bit);
  // R3: the load exposes bit 0 first
  p_lsb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && hold_valid) |=> (line_bit == $past(hold_data[0])));
endmodule

// File: rtl/ser_route_sel.sv
module ser_route_sel
  import ser_tx_pkg::*;
(
  input  route_e route,
  input  logic   line_bit,
  output logic   ser_out,
  output logic   wrap_out
);
  always_comb begin
    ser_out  = 1'b1;
    wrap_out = 1'b1;
    if (route == ROUTE_WRAP) wrap_out = line_bit;
    else                     ser_out  = line_bit;
  end
endmodule

// File: rtl/ser_loop_tx.sv
module ser_loop_tx
  import ser_tx_pkg::*;
#(
  parameter int unsigned WORD_W = ser_tx_pkg::SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              loop_en,
  output logic              ser_out,
  output logic              wrap_out
);
  logic              boundary;
  logic              hold_valid;
  logic [WORD_W-1:0] hold_data;
  logic              line_bit;
  route_e            route;

  ser_bit_counter #(.SYM_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .boundary(boundary));

  ser_word_latch #(.SYM_W(WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .boundary(boundary), .hold_valid(hold_valid),
    .hold_data(hold_data));

  ser_shifter #(.SYM_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .hold_valid(hold_valid),
    .hold_data(hold_data), .loop_req(loop_en), .line_bit(line_bit),
    .route(route));

  ser_route_sel u_sel (
    .route(route), .line_bit(line_bit), .ser_out(ser_out),
    .wrap_out(wrap_out));

  // R7: external pin is static high while wrapped
  p_ext_static_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_WRAP) |-> ser_out);
  // R6: wrap pin idles high while the external pin is active
  p_wrap_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_EXT) |-> wrap_out);
  // R2: every boundary can take a symbol
  p_ready_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> in_ready);
endmodule

// File: tb/tb_ser_loop_tx.sv
module tb_ser_loop_tx;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic loop_en = 1'b0;
  logic ser_out, wrap_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ser_loop_tx #(.WORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .loop_en(loop_en), .ser_out(ser_out),
    .wrap_out(wrap_out));

  // behavioural reference
  int       m_pos;
  logic [W-1:0] m_cur, m_hold;
  bit       m_full, m_loop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = W - 1; m_cur = '1; m_full = 0; m_loop = 0; m_hold = '0;
    end else begin
      bit acc;
      acc = in_valid && (!m_full || m_pos == W - 1);
      if (m_pos == W - 1) begin
        m_cur = m_full ? m_hold : '1;
        m_loop = loop_en;
        m_full = 0;
        m_pos = 0;
      end else begin
        m_pos++;
      end
      if (acc) begin m_hold = in_data; m_full = 1; end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic bitv;
    bitv = m_cur[m_pos];
    check("R3 R4 R5 R6 R7 ser_out", ser_out, m_loop ? 1'b1 : bitv);
    check("R3 R4 R5 R6 R7 R8 wrap_out", wrap_out, m_loop ? bitv : 1'b1);
    check("R2 in_ready", in_ready, !m_full || (m_pos == W - 1));
  endtask

  // mode: 0 loop low, 1 loop high, 2 random toggling; vpct: valid percentage
  task automatic run(int cycles, int vpct, int mode);
    bit pend = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      if (pend) begin
        in_valid = ($urandom_range(99) < vpct);
        in_data  = W'($urandom);
      end
      case (mode)
        0: loop_en = 1'b0;
        1: loop_en = 1'b1;
        default: if ($urandom_range(6) == 0) loop_en = ~loop_en; // R8 mid-word changes
      endcase
      pend = !in_valid || in_ready;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ser_out in reset", ser_out, 1'b1);
    check("R1 wrap_out in reset", wrap_out, 1'b1);
    check("R1 in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    run(25, 0, 0);      // R1 R5: idle ones after reset
    run(400, 100, 0);   // R3 R4 R6: back-to-back symbols
    run(400, 30, 0);    // R2 R5: sparse offers, back-pressure
    run(400, 100, 1);   // R7: wrapped stream
    run(800, 60, 2);    // R8: toggled loopback
    in_valid = 1'b0;
    run(30, 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule